// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block sits beside a load pipeline and answers one question per cycle: which bytes of a load can be taken from older stores that are still waiting in a small circular store queue, and what are those bytes? A load presents its virtual line address, its physical line address, a byte-enable mask over a 16-byte access and a bit-per-entry vector that marks which queue entries hold stores older than the load. The block returns a fast byte mask in the same cycle. One cycle later it returns the registered byte mask and the forwarded bytes, together with replay and flush indications.

The store queue is filled through two simple write ports. One writes an entry's address half: both line addresses and the byte mask. The other writes its data half. A tail pointer allocates entries and a head pointer frees them. Each pointer carries a wrap bit so that a full queue and an empty queue can be told apart. Only entries between head and tail that are also flagged in the load's older-store vector take part in a lookup.

When an overlapping store has a resolved address but no data yet, the load is told to replay and is given that store's index. An older store with an unresolved address is reported the same way. A disagreement between the physical-address match set and the virtual-address match set raises a flag so that the surrounding logic can flush.

Top module: `sqfwd_lookup`

## Requirements
- R1: After a synchronous reset both pointers read zero, the queue is empty, and every registered response output is zero.
- R2: Pointers are {wrap bit, 4-bit index}. A request to allocate is ignored when the queue holds 16 entries. A request to free is ignored when the queue is empty. The queue is empty when head equals tail and full when they differ only in the wrap bit.
- R3: `fast_fwd_mask` is combinational in the request cycle. Bit l is set when byte lane l of the load is supplied by a matching older store whose data is written.
- R4: `resp_valid`, `fwd_mask` and `fwd_data` appear exactly one cycle after the request. They are all zero in the cycle after a cycle with no request.
- R5: For each byte lane, the youngest matching older store that writes that lane supplies it, in queue age order from head, including across index wrap. Byte l of `fwd_data` is bits [8l+7:8l], and a lane that is not forwarded reads zero.
- R6: An entry takes part in a lookup only when it is allocated and its bit in `ld_older` is set.
- R7: An entry matches only when its line address equals the load's line address and its byte mask shares at least one set bit with the load mask.
- R8: `data_nrdy` (registered) and `fast_data_nrdy` (same cycle) are set when some lane's supplying store has no data written. `data_nrdy_idx` is the youngest such store's index, and 0 when the flag is clear.
- R9: `addr_nrdy` is set when a participating entry has no address written. `addr_nrdy_idx` is the youngest such entry, and 0 when the flag is clear.
- R10: `match_mismatch` is set when the set of entries matched by physical line address differs from the set matched by virtual line address.
- R11: Allocating an entry clears its address-written and data-written state, so stale contents are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Allocate the entry at the tail |
| free_en | input | 1 | Free the entry at the head |
| aw_en | input | 1 | Write an entry's address half |
| aw_idx | input | 4 | Entry index for the address write |
| aw_vline | input | 12 | Virtual line address for the address write |
| aw_pline | input | 16 | Physical line address for the address write |
| aw_mask | input | 16 | Store byte mask, bit l = lane l |
| dw_en | input | 1 | Write an entry's data half |
| dw_idx | input | 4 | Entry index for the data write |
| dw_data | input | 128 | Store data, lane l at bits [8l+7:8l] |
| ld_valid | input | 1 | Lookup request |
| ld_vline | input | 12 | Load virtual line address |
| ld_pline | input | 16 | Load physical line address |
| ld_mask | input | 16 | Load byte mask |
| ld_older | input | 16 | One bit per entry marking older stores |
| fast_fwd_mask | output | 16 | Same-cycle forwardable byte mask |
| fast_data_nrdy | output | 1 | Same-cycle data-not-ready flag |
| resp_valid | output | 1 | Registered response valid |
| fwd_mask | output | 16 | Registered forwarded byte mask |
| fwd_data | output | 128 | Registered forwarded bytes |
| data_nrdy | output | 1 | Registered data-not-ready flag |
| data_nrdy_idx | output | 4 | Index of the blocking store |
| addr_nrdy | output | 1 | Registered address-not-ready flag |
| addr_nrdy_idx | output | 4 | Index of the unresolved store |
| match_mismatch | output | 1 | Physical and virtual match sets differ |
| head_ptr | output | 5 | Head pointer with wrap bit |
| tail_ptr | output | 5 | Tail pointer with wrap bit |

## Verification
The directed patterns separate the cases one at a time. Stores cover partly overlapping lanes so that youngest-wins selection can be told apart from oldest-wins. Other loads shrink the older-store vector, move to a different line, or use a byte mask that does not overlap any store, which isolates the eligibility and overlap rules. One store's physical line is made to disagree with its virtual line to trigger the mismatch flag. The queue is driven to full, to empty and across index wrap, which separates pointer saturation, the clearing of stale entries and age order across the wrap boundary. A long random phase then mixes allocation, freeing, both write ports and lookups over two nearby lines and is compared every cycle against a behavioural queue model.

// File: rtl/sqfwd_pkg.sv
package sqfwd_pkg;
  localparam int BYTE_W        = 8;
  localparam int DEF_DEPTH     = 16;
  localparam int DEF_LANES     = 16;
  localparam int DEF_VLINE_W   = 12;
  localparam int DEF_PLINE_W   = 16;
endpackage

// File: rtl/sqfwd_ptrs.sv
module sqfwd_ptrs #(
  parameter int DEPTH = sqfwd_pkg::DEF_DEPTH,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic             free_en,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic             alloc_fire,
  output logic [DEPTH-1:0] alloc_vec
);
  logic [PTR_W-1:0] count;
  logic             full, empty, free_fire;

  assign count      = tail_q - head_q;
  assign full       = (count == PTR_W'(DEPTH));
  assign empty      = (count == '0);
  assign alloc_fire = alloc_en & ~full;
  assign free_fire  = free_en & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (free_fire)  head_q <= head_q + 1'b1;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_live
    logic [IDX_W-1:0] age;
    assign age          = IDX_W'(e) - head_q[IDX_W-1:0];
    assign alloc_vec[e] = ({1'b0, age} < count);
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= PTR_W'(DEPTH));
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && alloc_en) |=> tail_q == $past(tail_q));
  // R2
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && free_en) |=> head_q == $past(head_q));
endmodule

// File: rtl/sqfwd_store.sv
module sqfwd_store #(
  parameter int DEPTH   = sqfwd_pkg::DEF_DEPTH,
  parameter int LANES   = sqfwd_pkg::DEF_LANES,
  parameter int VLINE_W = sqfwd_pkg::DEF_VLINE_W,
  parameter int PLINE_W = sqfwd_pkg::DEF_PLINE_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BW     = sqfwd_pkg::BYTE_W
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  alloc_fire,
  input  logic [IDX_W-1:0]                      alloc_idx,
  input  logic                                  aw_en,
  input  logic [IDX_W-1:0]                      aw_idx,
  input  logic [VLINE_W-1:0]                    aw_vline,
  input  logic [PLINE_W-1:0]                    aw_pline,
  input  logic [LANES-1:0]                      aw_mask,
  input  logic                                  dw_en,
  input  logic [IDX_W-1:0]                      dw_idx,
  input  logic [LANES-1:0][BW-1:0]              dw_data,
  output logic [DEPTH-1:0]                      av_q,
  output logic [DEPTH-1:0]                      dv_q,
  output logic [DEPTH-1:0][VLINE_W-1:0]         vline_q,
  output logic [DEPTH-1:0][PLINE_W-1:0]         pline_q,
  output logic [DEPTH-1:0][LANES-1:0]           mask_q,
  output logic [DEPTH-1:0][LANES-1:0][BW-1:0]   data_q
);
  // State bits: reset, cleared on allocation, set by the writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      av_q <= '0;
      dv_q <= '0;
    end else begin
      if (alloc_fire) begin
        av_q[alloc_idx] <= 1'b0;
        dv_q[alloc_idx] <= 1'b0;
      end
      if (aw_en) av_q[aw_idx] <= 1'b1;
      if (dw_en) dv_q[dw_idx] <= 1'b1;
    end
  end

  // Payload storage: written without reset, RAM-style.
  always_ff @(posedge clk) begin
    if (aw_en) begin
      vline_q[aw_idx] <= aw_vline;
      pline_q[aw_idx] <= aw_pline;
      mask_q[aw_idx]  <= aw_mask;
    end
    if (dw_en) data_q[dw_idx] <= dw_data;
  end

  // R11
  alloc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !(aw_en && aw_idx == alloc_idx)) |=> !av_q[$past(alloc_idx)]);
endmodule

// File: rtl/sqfwd_match.sv
module sqfwd_match #(
  parameter int DEPTH   = sqfwd_pkg::DEF_DEPTH,
  parameter int LANES   = sqfwd_pkg::DEF_LANES,
  parameter int VLINE_W = sqfwd_pkg::DEF_VLINE_W,
  parameter int PLINE_W = sqfwd_pkg::DEF_PLINE_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BW     = sqfwd_pkg::BYTE_W
) (
  input  logic [IDX_W-1:0]                      head_idx,
  input  logic [DEPTH-1:0]                      alloc_vec,
  input  logic [DEPTH-1:0]                      av_q,
  input  logic [DEPTH-1:0]                      dv_q,
  input  logic [DEPTH-1:0][VLINE_W-1:0]         vline_q,
  input  logic [DEPTH-1:0][PLINE_W-1:0]         pline_q,
  input  logic [DEPTH-1:0][LANES-1:0]           mask_q,
  input  logic [DEPTH-1:0][LANES-1:0][BW-1:0]   data_q,
  input  logic                                  ld_valid,
  input  logic [VLINE_W-1:0]                    ld_vline,
  input  logic [PLINE_W-1:0]                    ld_pline,
  input  logic [LANES-1:0]                      ld_mask,
  input  logic [DEPTH-1:0]                      ld_older,
  output logic [LANES-1:0]                      fmask,
  output logic [LANES-1:0][BW-1:0]              fdata,
  output logic                                  dnr,
  output logic [IDX_W-1:0]                      dnr_idx,
  output logic                                  anr,
  output logic [IDX_W-1:0]                      anr_idx,
  output logic                                  mism
);
  function automatic logic [IDX_W-1:0] slot_at(input logic [IDX_W-1:0] h, input int k);
    slot_at = h + k[IDX_W-1:0];
  endfunction

  logic [DEPTH-1:0] elig, ovl, vhit, phit, unk, blk;
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0][IDX_W-1:0] lane_sel;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign elig[e] = ld_valid & alloc_vec[e] & ld_older[e];
    assign ovl[e]  = |(mask_q[e] & ld_mask);
    assign vhit[e] = elig[e] & av_q[e] & ovl[e] & (vline_q[e] == ld_vline);
    assign phit[e] = elig[e] & av_q[e] & ovl[e] & (pline_q[e] == ld_pline);
    assign unk[e]  = elig[e] & ~av_q[e];
  end

  // Per lane: walk from oldest to youngest, the last hit wins.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             hit_l;
    logic [IDX_W-1:0] sel_l;
    always_comb begin
      hit_l = 1'b0;
      sel_l = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (vhit[slot_at(head_idx, k)] && mask_q[slot_at(head_idx, k)][l] && ld_mask[l]) begin
          hit_l = 1'b1;
          sel_l = slot_at(head_idx, k);
        end
      end
    end
    assign lane_hit[l] = hit_l;
    assign lane_sel[l] = sel_l;
    assign fmask[l]    = hit_l & dv_q[sel_l];
    assign fdata[l]    = fmask[l] ? data_q[sel_l][l] : '0;
  end

  always_comb begin
    blk = '0;
    for (int l = 0; l < LANES; l++)
      if (lane_hit[l] && !dv_q[lane_sel[l]]) blk[lane_sel[l]] = 1'b1;
  end

  always_comb begin
    dnr_idx = '0;
    anr_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (blk[slot_at(head_idx, k)]) dnr_idx = slot_at(head_idx, k);
      if (unk[slot_at(head_idx, k)]) anr_idx = slot_at(head_idx, k);
    end
  end

  assign dnr  = |blk;
  assign anr  = |unk;
  assign mism = (vhit != phit);
endmodule

// File: rtl/sqfwd_lookup.sv
module sqfwd_lookup #(
  parameter int DEPTH   = sqfwd_pkg::DEF_DEPTH,
  parameter int LANES   = sqfwd_pkg::DEF_LANES,
  parameter int VLINE_W = sqfwd_pkg::DEF_VLINE_W,
  parameter int PLINE_W = sqfwd_pkg::DEF_PLINE_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int DATA_W = LANES * sqfwd_pkg::BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic               free_en,
  input  logic               aw_en,
  input  logic [IDX_W-1:0]   aw_idx,
  input  logic [VLINE_W-1:0] aw_vline,
  input  logic [PLINE_W-1:0] aw_pline,
  input  logic [LANES-1:0]   aw_mask,
  input  logic               dw_en,
  input  logic [IDX_W-1:0]   dw_idx,
  input  logic [DATA_W-1:0]  dw_data,
  input  logic               ld_valid,
  input  logic [VLINE_W-1:0] ld_vline,
  input  logic [PLINE_W-1:0] ld_pline,
  input  logic [LANES-1:0]   ld_mask,
  input  logic [DEPTH-1:0]   ld_older,
  output logic [LANES-1:0]   fast_fwd_mask,
  output logic               fast_data_nrdy,
  output logic               resp_valid,
  output logic [LANES-1:0]   fwd_mask,
  output logic [DATA_W-1:0]  fwd_data,
  output logic               data_nrdy,
  output logic [IDX_W-1:0]   data_nrdy_idx,
  output logic               addr_nrdy,
  output logic [IDX_W-1:0]   addr_nrdy_idx,
  output logic               match_mismatch,
  output logic [PTR_W-1:0]   head_ptr,
  output logic [PTR_W-1:0]   tail_ptr
);
  localparam int BW = sqfwd_pkg::BYTE_W;

  logic                                alloc_fire;
  logic [DEPTH-1:0]                    alloc_vec, av_q, dv_q;
  logic [DEPTH-1:0][VLINE_W-1:0]       vline_q;
  logic [DEPTH-1:0][PLINE_W-1:0]       pline_q;
  logic [DEPTH-1:0][LANES-1:0]         mask_q;
  logic [DEPTH-1:0][LANES-1:0][BW-1:0] data_q;
  logic [LANES-1:0][BW-1:0]            m_fdata;
  logic                                m_dnr, m_anr, m_mism;
  logic [IDX_W-1:0]                    m_dnr_idx, m_anr_idx;

  sqfwd_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .free_en(free_en),
    .head_q(head_ptr), .tail_q(tail_ptr),
    .alloc_fire(alloc_fire), .alloc_vec(alloc_vec));

  sqfwd_store #(.DEPTH(DEPTH), .LANES(LANES), .VLINE_W(VLINE_W), .PLINE_W(PLINE_W)) u_store (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_idx(tail_ptr[IDX_W-1:0]),
    .aw_en(aw_en), .aw_idx(aw_idx), .aw_vline(aw_vline), .aw_pline(aw_pline),
    .aw_mask(aw_mask), .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
    .av_q(av_q), .dv_q(dv_q), .vline_q(vline_q), .pline_q(pline_q),
    .mask_q(mask_q), .data_q(data_q));

  sqfwd_match #(.DEPTH(DEPTH), .LANES(LANES), .VLINE_W(VLINE_W), .PLINE_W(PLINE_W)) u_match (
    .head_idx(head_ptr[IDX_W-1:0]), .alloc_vec(alloc_vec),
    .av_q(av_q), .dv_q(dv_q), .vline_q(vline_q), .pline_q(pline_q),
    .mask_q(mask_q), .data_q(data_q),
    .ld_valid(ld_valid), .ld_vline(ld_vline), .ld_pline(ld_pline),
    .ld_mask(ld_mask), .ld_older(ld_older),
    .fmask(fast_fwd_mask), .fdata(m_fdata),
    .dnr(m_dnr), .dnr_idx(m_dnr_idx), .anr(m_anr), .anr_idx(m_anr_idx), .mism(m_mism));

  assign fast_data_nrdy = m_dnr;

  // Second stage: registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid     <= 1'b0;
      fwd_mask       <= '0;
      fwd_data       <= '0;
      data_nrdy      <= 1'b0;
      data_nrdy_idx  <= '0;
      addr_nrdy      <= 1'b0;
      addr_nrdy_idx  <= '0;
      match_mismatch <= 1'b0;
    end else begin
      resp_valid     <= ld_valid;
      fwd_mask       <= fast_fwd_mask;
      fwd_data       <= m_fdata;
      data_nrdy      <= m_dnr;
      data_nrdy_idx  <= m_dnr_idx;
      addr_nrdy      <= m_anr;
      addr_nrdy_idx  <= m_anr_idx;
      match_mismatch <= m_mism;
    end
  end

  // R4
  resp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> resp_valid == $past(ld_valid));
  // R4
  mask_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fwd_mask == $past(fast_fwd_mask));
  // R8
  nrdy_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> data_nrdy == $past(fast_data_nrdy));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> (fwd_mask == '0 && !data_nrdy && !addr_nrdy && !match_mismatch));
endmodule

// File: tb/sqfwd_lookup_tb.sv
module sqfwd_lookup_tb;
  localparam int CLK_NS = 10;

  logic         clk, rst;
  logic         alloc_en, free_en, aw_en, dw_en, ld_valid;
  logic [3:0]   aw_idx, dw_idx;
  logic [11:0]  aw_vline, ld_vline;
  logic [15:0]  aw_pline, ld_pline, aw_mask, ld_mask, ld_older;
  logic [127:0] dw_data;
  logic [15:0]  fast_fwd_mask, fwd_mask;
  logic         fast_data_nrdy, resp_valid, data_nrdy, addr_nrdy, match_mismatch;
  logic [127:0] fwd_data;
  logic [3:0]   data_nrdy_idx, addr_nrdy_idx;
  logic [4:0]   head_ptr, tail_ptr;

  sqfwd_lookup u_dut (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .free_en(free_en),
    .aw_en(aw_en), .aw_idx(aw_idx), .aw_vline(aw_vline), .aw_pline(aw_pline), .aw_mask(aw_mask),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
    .ld_valid(ld_valid), .ld_vline(ld_vline), .ld_pline(ld_pline), .ld_mask(ld_mask), .ld_older(ld_older),
    .fast_fwd_mask(fast_fwd_mask), .fast_data_nrdy(fast_data_nrdy),
    .resp_valid(resp_valid), .fwd_mask(fwd_mask), .fwd_data(fwd_data),
    .data_nrdy(data_nrdy), .data_nrdy_idx(data_nrdy_idx),
    .addr_nrdy(addr_nrdy), .addr_nrdy_idx(addr_nrdy_idx),
    .match_mismatch(match_mismatch), .head_ptr(head_ptr), .tail_ptr(tail_ptr));

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Behavioural queue model
  logic         m_av [16];
  logic         m_dv [16];
  logic [11:0]  m_vl [16];
  logic [15:0]  m_pl [16];
  logic [15:0]  m_mk [16];
  logic [127:0] m_dt [16];
  int           m_head, m_tail;

  // Expected values: c_ = this cycle's lookup, r_ = registered response
  logic [15:0]  c_fmask, r_fmask, n_fmask;
  logic [127:0] c_fdata, r_fdata, n_fdata;
  logic         c_dnr, r_dnr, n_dnr, c_anr, r_anr, n_anr, c_mm, r_mm, n_mm, r_rv, n_rv;
  int           c_dnr_idx, r_dnr_idx, n_dnr_idx, c_anr_idx, r_anr_idx, n_anr_idx;

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int agef(input int e);
    return (e - m_head) & 15;
  endfunction

  task automatic model_calc();
    int cnt, best, best_age, blk_age, unk_age;
    logic [15:0] vm, pm;
    c_fmask = '0; c_fdata = '0; c_dnr = 0; c_dnr_idx = 0;
    c_anr = 0; c_anr_idx = 0; c_mm = 0;
    if (ld_valid) begin
      cnt = (m_tail - m_head) & 31;
      vm = '0; pm = '0; unk_age = -1; blk_age = -1;
      for (int e = 0; e < 16; e++) begin
        if (agef(e) < cnt && ld_older[e]) begin
          if (!m_av[e]) begin
            if (agef(e) > unk_age) begin unk_age = agef(e); c_anr = 1; c_anr_idx = e; end
          end else if ((m_mk[e] & ld_mask) != 0) begin
            vm[e] = (m_vl[e] == ld_vline);
            pm[e] = (m_pl[e] == ld_pline);
          end
        end
      end
      c_mm = (vm != pm);
      for (int l = 0; l < 16; l++) begin
        best = -1; best_age = -1;
        for (int e = 0; e < 16; e++)
          if (vm[e] && m_mk[e][l] && ld_mask[l] && agef(e) > best_age) begin
            best = e; best_age = agef(e);
          end
        if (best >= 0) begin
          if (m_dv[best]) begin
            c_fmask[l] = 1'b1;
            c_fdata[8*l +: 8] = m_dt[best][8*l +: 8];
          end else if (best_age > blk_age) begin
            blk_age = best_age; c_dnr = 1; c_dnr_idx = best;
          end
        end
      end
    end
  endtask

  task automatic model_update();
    int cnt, e;
    cnt = (m_tail - m_head) & 31;
    if (alloc_en && cnt != 16) begin
      e = m_tail & 15; m_av[e] = 0; m_dv[e] = 0; m_tail = (m_tail + 1) & 31;
    end
    if (free_en && cnt != 0) m_head = (m_head + 1) & 31;
    if (aw_en) begin
      m_av[aw_idx] = 1; m_vl[aw_idx] = aw_vline; m_pl[aw_idx] = aw_pline; m_mk[aw_idx] = aw_mask;
    end
    if (dw_en) begin m_dv[dw_idx] = 1; m_dt[dw_idx] = dw_data; end
  endtask

  // One clock: compare every output against the model, then advance.
  task automatic step();
    #1;
    model_calc();
    chk("R3 fast_fwd_mask", fast_fwd_mask, c_fmask);
    chk("R8 fast_data_nrdy", fast_data_nrdy, c_dnr);
    chk("R4 resp_valid", resp_valid, r_rv);
    chk("R5 fwd_mask", fwd_mask, r_fmask);
    chk("R5 fwd_data", fwd_data, r_fdata);
    chk("R8 data_nrdy", data_nrdy, r_dnr);
    chk("R8 data_nrdy_idx", data_nrdy_idx, r_dnr_idx);
    chk("R9 addr_nrdy", addr_nrdy, r_anr);
    chk("R9 addr_nrdy_idx", addr_nrdy_idx, r_anr_idx);
    chk("R10 match_mismatch", match_mismatch, r_mm);
    chk("R2 head_ptr", head_ptr, m_head);
    chk("R2 tail_ptr", tail_ptr, m_tail);
    n_rv = ld_valid; n_fmask = c_fmask; n_fdata = c_fdata; n_dnr = c_dnr;
    n_dnr_idx = c_dnr_idx; n_anr = c_anr; n_anr_idx = c_anr_idx; n_mm = c_mm;
    @(posedge clk);
    model_update();
    r_rv = n_rv; r_fmask = n_fmask; r_fdata = n_fdata; r_dnr = n_dnr;
    r_dnr_idx = n_dnr_idx; r_anr = n_anr; r_anr_idx = n_anr_idx; r_mm = n_mm;
    @(negedge clk);
  endtask

  task automatic t_alloc(input int n);
    repeat (n) begin alloc_en = 1; step(); end
    alloc_en = 0;
  endtask
  task automatic t_free(input int n);
    repeat (n) begin free_en = 1; step(); end
    free_en = 0;
  endtask
  task automatic t_aw(input int idx, input logic [11:0] vl, input logic [15:0] pl, input logic [15:0] mk);
    aw_en = 1; aw_idx = 4'(idx); aw_vline = vl; aw_pline = pl; aw_mask = mk;
    step(); aw_en = 0;
  endtask
  task automatic t_dw(input int idx, input logic [127:0] d);
    dw_en = 1; dw_idx = 4'(idx); dw_data = d;
    step(); dw_en = 0;
  endtask
  task automatic t_look(input logic [11:0] vl, input logic [15:0] pl, input logic [15:0] mk, input logic [15:0] old);
    ld_valid = 1; ld_vline = vl; ld_pline = pl; ld_mask = mk; ld_older = old;
    step(); ld_valid = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; alloc_en = 0; free_en = 0; aw_en = 0; dw_en = 0; ld_valid = 0;
    aw_idx = 0; dw_idx = 0; aw_vline = 0; aw_pline = 0; aw_mask = 0; dw_data = 0;
    ld_vline = 0; ld_pline = 0; ld_mask = 0; ld_older = 0;
    for (int e = 0; e < 16; e++) begin
      m_av[e] = 0; m_dv[e] = 0; m_vl[e] = 0; m_pl[e] = 0; m_mk[e] = 0; m_dt[e] = 0;
    end
    m_head = 0; m_tail = 0;
    r_rv = 0; r_fmask = 0; r_fdata = 0; r_dnr = 0; r_dnr_idx = 0; r_anr = 0; r_anr_idx = 0; r_mm = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 head after reset", head_ptr, 0);
    chk("R1 tail after reset", tail_ptr, 0);
    chk("R1 resp_valid after reset", resp_valid, 0);
    chk("R1 fwd_mask after reset", fwd_mask, 0);
    chk("R1 flags after reset", {data_nrdy, addr_nrdy, match_mismatch}, 0);
    step(); step();

    // Four stores, addresses unknown at first
    t_alloc(4);
    t_look(12'h123, 16'h3123, 16'hFFFF, 16'h000F);
    chk("R9 unresolved flag", addr_nrdy, 1);
    chk("R9 youngest unresolved index", addr_nrdy_idx, 3);

    t_aw(0, 12'h123, 16'h3123, 16'h00FF);
    t_aw(1, 12'h123, 16'h3123, 16'h0FF0);
    t_aw(2, 12'h456, 16'h3456, 16'hFFFF);
    t_aw(3, 12'h123, 16'h3123, 16'hF000);
    t_dw(0, {16{8'hA0}});
    t_dw(1, {16{8'hB1}});
    t_dw(2, {16{8'hD2}});

    ld_valid = 1; ld_vline = 12'h123; ld_pline = 16'h3123; ld_mask = 16'hFFFF; ld_older = 16'h000F;
    #1;
    chk("R3 same-cycle mask", fast_fwd_mask, 16'h0FFF);
    chk("R8 same-cycle not-ready", fast_data_nrdy, 1);
    step(); ld_valid = 0;
    chk("R5 youngest lanes mask", fwd_mask, 16'h0FFF);
    chk("R5 youngest lanes data", fwd_data, 128'h00000000_B1B1B1B1_B1B1B1B1_A0A0A0A0);
    chk("R8 blocking store", data_nrdy, 1);
    chk("R8 blocking index", data_nrdy_idx, 3);
    chk("R4 response valid", resp_valid, 1);
    step();
    chk("R4 no response after idle", resp_valid, 0);

    t_look(12'h123, 16'h3123, 16'hFFFF, 16'h0001);
    chk("R6 older vector limits mask", fwd_mask, 16'h00FF);
    chk("R6 no blocker outside vector", data_nrdy, 0);

    t_look(12'h124, 16'h3124, 16'hFFFF, 16'h000F);
    chk("R7 other line no forward", fwd_mask, 16'h0000);
    t_look(12'h123, 16'h3123, 16'h0F00, 16'h0009);
    chk("R7 no byte overlap", {fwd_mask, data_nrdy}, 0);

    t_aw(3, 12'h123, 16'h3999, 16'hF000);
    t_look(12'h123, 16'h3123, 16'hFFFF, 16'h000F);
    chk("R10 physical/virtual disagree", match_mismatch, 1);

    t_aw(3, 12'h123, 16'h3123, 16'hF000);
    t_dw(3, {16{8'hC3}});
    t_look(12'h123, 16'h3123, 16'hFFFF, 16'h000F);
    chk("R10 agreement clears", match_mismatch, 0);
    chk("R8 data now present", data_nrdy, 0);
    chk("R5 full merge", fwd_data, 128'hC3C3C3C3_B1B1B1B1_B1B1B1B1_A0A0A0A0);

    // Pointer limits
    t_free(4);
    t_free(1);
    chk("R2 free on empty ignored", head_ptr, 5'd4);
    t_alloc(16);
    t_alloc(1);
    chk("R2 alloc on full ignored", tail_ptr, 5'd20);

    t_look(12'h123, 16'h3123, 16'hFFFF, 16'hFFFF);
    chk("R11 stale data not forwarded", fwd_mask, 16'h0000);
    chk("R11 reallocated entries unresolved", addr_nrdy_idx, 3);

    // Age order across index wrap: head at 14
    t_free(10);
    t_aw(15, 12'h123, 16'h3123, 16'hFFFF);
    t_dw(15, {16{8'hE5}});
    t_aw(0, 12'h123, 16'h3123, 16'h00FF);
    t_dw(0, {16{8'h0F}});
    t_look(12'h123, 16'h3123, 16'hFFFF, 16'h8001);
    chk("R5 wrap youngest mask", fwd_mask, 16'hFFFF);
    chk("R5 wrap youngest data", fwd_data, 128'hE5E5E5E5_E5E5E5E5_0F0F0F0F_0F0F0F0F);
    t_look(12'h123, 16'h3123, 16'hFFFF, 16'hC001);
    chk("R9 wrap unresolved index", addr_nrdy_idx, 14);

    // Random mix, compared against the model every cycle
    for (int i = 0; i < 800; i++) begin
      logic [11:0] vl;
      alloc_en = ($urandom() % 3) == 0;
      free_en  = ($urandom() % 4) == 0;
      aw_en    = ($urandom() % 2) == 0;
      aw_idx   = 4'($urandom());
      aw_vline = 12'h120 + 12'($urandom() % 2);
      aw_pline = (($urandom() % 8) == 0) ? 16'h3999 : {4'h3, aw_vline};
      aw_mask  = 16'($urandom());
      dw_en    = ($urandom() % 2) == 0;
      dw_idx   = 4'($urandom());
      dw_data  = {$urandom(), $urandom(), $urandom(), $urandom()};
      ld_valid = ($urandom() % 2) == 0;
      vl       = 12'h120 + 12'($urandom() % 2);
      ld_vline = vl;
      ld_pline = {4'h3, vl};
      ld_mask  = 16'($urandom());
      ld_older = 16'($urandom());
      step();
    end
    alloc_en = 0; free_en = 0; aw_en = 0; dw_en = 0; ld_valid = 0;
    step(); step();

    done = 1;
    summary();
    $finish;
  end
endmodule